// File: doc/BRIEF.md
# Stream identifier span filter matcher

This block decides, one event at a time, whether a tagged transaction should be counted by a performance counter. Each event arrives with a valid strobe and an identifier of `ID_W` bits. The identifier is compared against a programmed filter value. One cycle after the strobe, a registered qualifier tells the counter whether to increment.

Two comparison modes exist. In exact mode the whole identifier must equal the filter. In span mode the filter value also carries the width of a don't-care field. That width is encoded as a zero bit placed above a run of trailing ones. The zero bit, and every bit below it, is ignored during the comparison. All bits above the zero bit must match. There is no separate mask register; the mask is derived from the filter value itself.

When filtering is switched off, the block behaves as if span mode were selected with an all-ones filter value. Every valid event then qualifies.

Top module: `sid_span_match`

## Requirements
- R1: While reset is asserted (`rst_n` low), and in the first cycle after it is released, `hit_o` is 0.
- R2: With `flt_en_i`=1 and `span_i`=0, an event qualifies only if `ev_id_i` equals `flt_val_i` in all `ID_W` bits.
- R3: With `flt_en_i`=1 and `span_i`=1, let Y be one more than the number of consecutive ones counted upward from bit 0 of `flt_val_i`. Identifier bits Y-1 down to 0 are ignored, and bits from Y upward must equal the filter.
- R4: With span mode and a filter whose bit 0 is 0, only bit 0 is ignored. For example, filter 0x42 qualifies identifiers 0x42 and 0x43 and rejects all others, such as 0x40, 0x41 and 0xC2.
- R5: With span mode and an all-ones filter, every identifier qualifies.
- R6: With `flt_en_i`=0, every valid event qualifies, whatever the values of `flt_val_i` and `span_i`.
- R7: `hit_o` is updated at the clock edge that samples `ev_vld_i`. It is 1 only if `ev_vld_i` was 1 at that edge and the event qualified; otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_en_i | input | 1 | Filtering enabled (0 = count every event) |
| span_i | input | 1 | 0 = exact compare, 1 = trailing-ones span compare |
| flt_val_i | input | ID_W | Programmed filter value |
| ev_vld_i | input | 1 | Event strobe |
| ev_id_i | input | ID_W | Identifier of the event |
| hit_o | output | 1 | Registered qualifier for the counter |

## Verification
The bench targets the filter values that sit at the edges of the mask encoding:
- **0x0 and 0x1.** A design that took the mask from the lowest zero bit alone, or that skipped the zero bit, would reject 0x1 or accept 0x2 against filter 0x0.
- **All ones.** A design that let the increment carry wrap into the mask would fail to match arbitrary identifiers against an all-ones span filter.
- **Filter 0x42.** A one-bit error in the width of the ignored field would show up as a match on 0x41 or 0x40, or as a rejection of 0x43.

Random pairs are skewed so that most identifiers differ from the filter only in a few low bits. This exercises both sides of the mask boundary. A matcher that compared in span mode while exact mode was selected, or that reported a hit without the strobe, would raise a false count.

// File: rtl/sid_span_match.sv
module sid_span_match #(
  parameter int ID_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flt_en_i,
  input  logic            span_i,
  input  logic [ID_W-1:0] flt_val_i,
  input  logic            ev_vld_i,
  input  logic [ID_W-1:0] ev_id_i,
  output logic            hit_o
);

  logic [ID_W-1:0] eff_flt;
  logic            eff_span;
  logic [ID_W-1:0] dc_mask;
  logic [ID_W-1:0] diff;
  logic            qual;

  assign eff_flt  = flt_en_i ? flt_val_i : {ID_W{1'b1}};
  assign eff_span = flt_en_i ? span_i : 1'b1;

  // zero bit plus the trailing ones below it
  assign dc_mask  = eff_span ? (eff_flt ^ (eff_flt + 1'b1)) : '0;
  assign diff     = (ev_id_i ^ eff_flt) & ~dc_mask;
  assign qual     = (diff == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) hit_o <= 1'b0;
    else        hit_o <= ev_vld_i & qual;
  end

endmodule

// File: rtl/sid_span_match_chk.sv
module sid_span_match_chk #(
  parameter int ID_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            flt_en_i,
  input logic            span_i,
  input logic [ID_W-1:0] flt_val_i,
  input logic            ev_vld_i,
  input logic [ID_W-1:0] ev_id_i,
  input logic            hit_o
);

  assert_no_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_vld_i |=> !hit_o);

  assert_exact_eq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_vld_i && flt_en_i && !span_i && ev_id_i == flt_val_i) |=> hit_o);

  assert_exact_ne_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_vld_i && flt_en_i && !span_i && ev_id_i != flt_val_i) |=> !hit_o);

  assert_span_self_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_vld_i && flt_en_i && span_i && ev_id_i == flt_val_i) |=> hit_o);

  assert_all_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_vld_i && span_i && flt_val_i == {ID_W{1'b1}}) |=> hit_o);

  assert_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_vld_i && !flt_en_i) |=> hit_o);

  assert_reset_low_R1: assert property (@(posedge clk)
    !rst_n |=> !hit_o);

endmodule

bind sid_span_match sid_span_match_chk #(.ID_W(ID_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .flt_en_i(flt_en_i), .span_i(span_i),
  .flt_val_i(flt_val_i), .ev_vld_i(ev_vld_i), .ev_id_i(ev_id_i), .hit_o(hit_o)
);

// File: tb/sid_span_match_tb_top.sv
`timescale 1ns/1ps
module sid_span_match_tb_top;
  localparam int ID_W = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            flt_en_i = 1'b0;
  logic            span_i = 1'b0;
  logic [ID_W-1:0] flt_val_i = '0;
  logic            ev_vld_i = 1'b0;
  logic [ID_W-1:0] ev_id_i = '0;
  logic            hit_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sid_span_match #(.ID_W(ID_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .flt_en_i(flt_en_i), .span_i(span_i),
    .flt_val_i(flt_val_i), .ev_vld_i(ev_vld_i), .ev_id_i(ev_id_i), .hit_o(hit_o)
  );

  function automatic logic [ID_W-1:0] ref_mask(input logic [ID_W-1:0] f);
    logic [ID_W-1:0] m;
    bit run;
    m = '0;
    run = 1'b1;
    for (int i = 0; i < ID_W; i++) begin
      if (run) begin
        m[i] = 1'b1;
        if (!f[i]) run = 1'b0;
      end
    end
    return m;
  endfunction

  function automatic bit ref_hit(input bit vld, input bit en, input bit sp,
                                 input logic [ID_W-1:0] f, input logic [ID_W-1:0] id);
    logic [ID_W-1:0] m;
    if (!vld) return 1'b0;
    if (!en) return 1'b1;
    if (!sp) return id == f;
    m = ref_mask(f);
    return ((id & ~m) == (f & ~m));
  endfunction

  task automatic check(input string req, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: hit_o actual=%0b expected=%0b (flt=%h id=%h)",
               req, act, exp, flt_val_i, ev_id_i);
    end
  endtask

  task automatic apply(input string req, input bit vld, input bit en, input bit sp,
                       input logic [ID_W-1:0] f, input logic [ID_W-1:0] id);
    bit exp;
    @(negedge clk);
    ev_vld_i = vld; flt_en_i = en; span_i = sp; flt_val_i = f; ev_id_i = id;
    exp = ref_hit(vld, en, sp, f, id);
    @(negedge clk);
    check(req, hit_o, exp);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    ev_vld_i = 1'b1; flt_en_i = 1'b0;
    @(negedge clk);
    check("R1", hit_o, 1'b0);
    rst_n = 1'b1;
    check("R1", hit_o, 1'b0);

    apply("R2", 1, 1, 0, 32'h0000_1234, 32'h0000_1234);
    apply("R2", 1, 1, 0, 32'h0000_1234, 32'h0000_1235);
    apply("R2", 1, 1, 0, 32'h0000_0000, 32'h0000_0001);
    apply("R2", 1, 1, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    apply("R4", 1, 1, 1, 32'h42, 32'h42);
    apply("R4", 1, 1, 1, 32'h42, 32'h43);
    apply("R4", 1, 1, 1, 32'h42, 32'h41);
    apply("R4", 1, 1, 1, 32'h42, 32'h40);
    apply("R4", 1, 1, 1, 32'h42, 32'hC2);
    apply("R4", 1, 1, 1, 32'h0, 32'h1);
    apply("R4", 1, 1, 1, 32'h0, 32'h2);
    apply("R3", 1, 1, 1, 32'h1, 32'h2);
    apply("R3", 1, 1, 1, 32'h1, 32'h3);
    apply("R3", 1, 1, 1, 32'h1, 32'h4);
    apply("R3", 1, 1, 1, 32'h0000_0457, 32'h0000_0440);
    apply("R3", 1, 1, 1, 32'h0000_0457, 32'h0000_0460);
    apply("R3", 1, 1, 1, 32'h7FFF_FFFF, 32'h0000_0000);
    apply("R3", 1, 1, 1, 32'h7FFF_FFFF, 32'h8000_0000);
    apply("R5", 1, 1, 1, 32'hFFFF_FFFF, 32'h0000_0000);
    apply("R5", 1, 1, 1, 32'hFFFF_FFFF, 32'hDEAD_BEEF);
    apply("R6", 1, 0, 0, 32'h0000_0042, 32'h1234_5678);
    apply("R6", 1, 0, 1, 32'h0000_0000, 32'hFFFF_FFFF);
    apply("R7", 0, 1, 0, 32'h55, 32'h55);
    apply("R7", 0, 0, 1, 32'h55, 32'h00);

    for (int n = 0; n < 3000; n++) begin
      logic [ID_W-1:0] f, id;
      bit en, sp, vld;
      f   = $urandom();
      if ($urandom_range(0, 3) == 0) f = f | ((32'h1 << $urandom_range(0, 12)) - 1);
      id  = f ^ ($urandom() & ((32'h1 << $urandom_range(0, 8)) - 1));
      if ($urandom_range(0, 7) == 0) id = $urandom();
      en  = ($urandom_range(0, 7) != 0);
      sp  = $urandom_range(0, 1);
      vld = ($urandom_range(0, 9) != 0);
      apply(!vld ? "R7" : !en ? "R6" : sp ? "R3" : "R2", vld, en, sp, f, id);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule